// File: doc/BRIEF.md
# Serial Configuration Stream Frame Checker

This block sits behind a one-bit configuration input and parses the stream as it arrives, one bit for each cycle in which the bit-enable qualifier is high. It looks for a run of ones followed by a short preamble. It then captures a 24-bit length word and checks the fill bits after it. Next it takes a fixed number of frames. Each frame is made of a zero start bit, a run of data bits and a constant four-bit trailer. Each accepted frame appears on a write port together with a one-cycle strobe and the frame's index. A one-byte postamble closes the stream.

Any marker that does not match moves the block into a locked error state, and the active-low error output is driven low. In this state the block ignores all stream input until the synchronous reprogram input is pulsed or reset is asserted. After a good postamble the done output goes high, and anything that follows in the stream is ignored. The captured length word is reported on an output but does not steer loading. The frame width and the frame count are parameters.

Top module: `cfgbit_frame_checker`

## Requirements
- R1: After reset or a reprogram pulse: err_n is 1, done is 0, frame_valid is 0 and length_valid is 0.
- R2: The block hunts for at least eight consecutive ones and then the preamble 0,0,1,0 (in arrival order). Any number of extra ones is accepted as fill. A zero that arrives before eight ones have been seen restarts the count and does not raise an error.
- R3: Once at least eight ones have been followed by a zero, the next three bits must be 0,1,0. Any mismatch sets err_n to 0.
- R4: The 24 bits after the preamble are captured MSB-first onto length_count, and length_valid goes high. The value has no effect on how many frames are loaded.
- R5: Four fill bits of value 1 follow the length. A 0 among them sets err_n to 0.
- R6: Every frame opens with a start bit of 0. A 1 in that position sets err_n to 0.
- R7: After the start bit, FRAME_BITS data bits are shifted in MSB-first, so the first data bit ends up in frame_data[FRAME_BITS-1]. One cycle after the edge that accepts the last trailer bit, frame_valid is high for exactly one cycle, with frame_data and frame_idx valid. frame_idx counts from 0.
- R8: Each frame's trailer must be 0,1,1,0 in arrival order. A mismatch sets err_n to 0 and no frame_valid is produced for that frame.
- R9: After FRAME_COUNT frames, the byte 0,1,1,1,1,1,1,1 (arrival order) must follow. If it matches, done goes to 1. If it does not, err_n goes to 0.
- R10: Once err_n is 0, it stays 0 and all bit input is ignored (no frame_valid, no done) until reprog or reset.
- R11: Once done is 1, it stays 1 and further bits are ignored (err_n stays 1, no frame_valid), whatever their value.
- R12: While bit_en is 0, bit_in has no effect on the block.
- R13: A reprog pulse returns the block from any state to hunting for the preamble, and a complete new stream then loads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reprog | input | 1 | Synchronous restart to preamble hunt; clears error and done |
| bit_en | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Serial configuration bit |
| frame_valid | output | 1 | One-cycle strobe for an accepted frame |
| frame_data | output | FRAME_BITS | Data bits of the accepted frame, first bit in the MSB |
| frame_idx | output | IDX_W | Index of the accepted frame |
| length_count | output | 24 | Captured length word |
| length_valid | output | 1 | length_count has been captured |
| done | output | 1 | Postamble verified |
| err_n | output | 1 | Low while locked in the error state |

## Verification
The bench builds the block with FRAME_BITS of 8 and FRAME_COUNT of 3. With these values, a complete stream of header, frames and postamble takes under a hundred bits. This lets every marker position be corrupted separately, and lets the frame index roll past its last value into the postamble within a short run. Two full streams with different lengths and data come from the vector table. They are separated by a reprogram pulse, which also shows that a length word of zero still loads all three frames.

// File: rtl/cfgbit_frame_checker.sv
`timescale 1ns/1ps
module cfgbit_frame_checker #(
  parameter int FRAME_BITS  = 16,
  parameter int FRAME_COUNT = 4,
  localparam int IDX_W = (FRAME_COUNT > 1) ? $clog2(FRAME_COUNT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reprog,
  input  logic                  bit_en,
  input  logic                  bit_in,
  output logic                  frame_valid,
  output logic [FRAME_BITS-1:0] frame_data,
  output logic [IDX_W-1:0]      frame_idx,
  output logic [23:0]           length_count,
  output logic                  length_valid,
  output logic                  done,
  output logic                  err_n
);

  localparam int LEN_BITS = 24;
  localparam int CNT_MAX  = (FRAME_BITS > LEN_BITS) ? FRAME_BITS : LEN_BITS;
  localparam int CW       = $clog2(CNT_MAX + 1);

  typedef enum logic [3:0] {
    S_HUNT, S_PRE, S_LEN, S_FILL, S_START, S_DATA, S_CHK, S_POST, S_DONE, S_ERR
  } state_t;

  state_t                st;
  logic [3:0]            ones;
  logic [CW-1:0]         cnt;
  logic [IDX_W-1:0]      fidx;
  logic [LEN_BITS-1:0]   len_sh;
  logic [FRAME_BITS-1:0] shreg;
  logic                  exp_bit;

  always_comb begin
    case (st)
      S_PRE:   exp_bit = (cnt == CW'(1));
      S_START: exp_bit = 1'b0;
      S_CHK:   exp_bit = (cnt == CW'(1)) || (cnt == CW'(2));
      S_POST:  exp_bit = (cnt != CW'(0));
      default: exp_bit = 1'b1;
    endcase
  end

  assign err_n = (st != S_ERR);
  assign done  = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n || reprog) begin
      st           <= S_HUNT;
      ones         <= '0;
      cnt          <= '0;
      fidx         <= '0;
      len_sh       <= '0;
      shreg        <= '0;
      frame_valid  <= 1'b0;
      frame_data   <= '0;
      frame_idx    <= '0;
      length_count <= '0;
      length_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (bit_en) begin
        case (st)
          S_HUNT: begin
            if (bit_in) begin
              if (ones != 4'd8) ones <= ones + 4'd1;
            end else if (ones == 4'd8) begin
              st  <= S_PRE;
              cnt <= '0;
            end else begin
              ones <= '0;
            end
          end
          S_PRE: begin
            if (bit_in != exp_bit) st <= S_ERR;
            else if (cnt == CW'(2)) begin
              st  <= S_LEN;
              cnt <= '0;
            end else cnt <= cnt + CW'(1);
          end
          S_LEN: begin
            len_sh <= {len_sh[LEN_BITS-2:0], bit_in};
            if (cnt == CW'(LEN_BITS - 1)) begin
              length_count <= {len_sh[LEN_BITS-2:0], bit_in};
              length_valid <= 1'b1;
              st           <= S_FILL;
              cnt          <= '0;
            end else cnt <= cnt + CW'(1);
          end
          S_FILL: begin
            if (bit_in != exp_bit) st <= S_ERR;
            else if (cnt == CW'(3)) begin
              st  <= S_START;
              cnt <= '0;
            end else cnt <= cnt + CW'(1);
          end
          S_START: begin
            if (bit_in != exp_bit) st <= S_ERR;
            else begin
              st  <= S_DATA;
              cnt <= '0;
            end
          end
          S_DATA: begin
            shreg <= FRAME_BITS'({shreg, bit_in});
            if (cnt == CW'(FRAME_BITS - 1)) begin
              st  <= S_CHK;
              cnt <= '0;
            end else cnt <= cnt + CW'(1);
          end
          S_CHK: begin
            if (bit_in != exp_bit) st <= S_ERR;
            else if (cnt == CW'(3)) begin
              frame_valid <= 1'b1;
              frame_data  <= shreg;
              frame_idx   <= fidx;
              cnt         <= '0;
              if (fidx == IDX_W'(FRAME_COUNT - 1)) st <= S_POST;
              else begin
                fidx <= fidx + IDX_W'(1);
                st   <= S_START;
              end
            end else cnt <= cnt + CW'(1);
          end
          S_POST: begin
            if (bit_in != exp_bit) st <= S_ERR;
            else if (cnt == CW'(7)) st <= S_DONE;
            else cnt <= cnt + CW'(1);
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module cfgbit_frame_checker_sva (
  input logic clk,
  input logic rst_n,
  input logic reprog,
  input logic bit_en,
  input logic frame_valid,
  input logic length_valid,
  input logic done,
  input logic err_n
);

  assert_reprog_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reprog |=> (err_n && !done && !frame_valid && !length_valid));

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  assert_error_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_n && !reprog) |=> (!err_n && !frame_valid && !done));

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !reprog) |=> (done && err_n && !frame_valid));

  assert_idle_no_effect_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !reprog) |=> (!frame_valid && $stable(err_n) && $stable(done) && $stable(length_valid)));

  assert_done_err_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && !err_n));

endmodule

bind cfgbit_frame_checker cfgbit_frame_checker_sva u_sva (.*);

// File: tb/cfgbit_frame_checker_tb.sv
`timescale 1ns/1ps
module cfgbit_frame_checker_tb_top;

  localparam int FB = 8;
  localparam int FC = 3;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reprog = 1'b0;
  logic          bit_en = 1'b0;
  logic          bit_in = 1'b0;
  logic          frame_valid;
  logic [FB-1:0] frame_data;
  logic [IW-1:0] frame_idx;
  logic [23:0]   length_count;
  logic          length_valid;
  logic          done;
  logic          err_n;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfgbit_frame_checker #(.FRAME_BITS(FB), .FRAME_COUNT(FC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reprog(reprog), .bit_en(bit_en), .bit_in(bit_in),
    .frame_valid(frame_valid), .frame_data(frame_data), .frame_idx(frame_idx),
    .length_count(length_count), .length_valid(length_valid),
    .done(done), .err_n(err_n));

  localparam logic [FB-1:0] DATA_TBL [0:5] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81, 8'h5A};
  localparam logic [23:0]   LEN_TBL  [0:1] = '{24'hC0FFEE, 24'h000000};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_reprog();
    @(negedge clk);
    reprog = 1'b1;
    @(negedge clk);
    reprog = 1'b0;
  endtask

  task automatic send_header(input logic [23:0] len, input int ones);
    send_bits('1, ones);
    send_bits(4'b0010, 4);
    send_bits(len, 24);
    send_bits(4'b1111, 4);
  endtask

  task automatic send_frame(input logic [FB-1:0] d, input logic [3:0] trl);
    send_bit(1'b0);
    send_bits(d, FB);
    send_bits(trl, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(err_n && !done && !frame_valid && !length_valid, "R1 reset", {err_n, done, frame_valid, length_valid}, 4'b1000);

    // Table of full streams: R2, R4, R7, R9, R13
    for (int v = 0; v < 2; v++) begin
      send_header(LEN_TBL[v], 8 + 5 * v);
      chk(length_valid && length_count == LEN_TBL[v], "R4 length", length_count, LEN_TBL[v]);
      for (int f = 0; f < FC; f++) begin
        send_frame(DATA_TBL[v * FC + f], 4'b0110);
        chk(frame_valid && frame_data == DATA_TBL[v * FC + f] && frame_idx == IW'(f),
            "R7 frame", {frame_valid, frame_idx, frame_data}, {1'b1, IW'(f), DATA_TBL[v * FC + f]});
        @(negedge clk);
        chk(!frame_valid, "R7 strobe width", frame_valid, 0);
      end
      chk(!done, "R9 done before postamble", done, 0);
      send_bits(8'b01111111, 8);
      chk(done && err_n, "R9 postamble", {done, err_n}, 2'b11);
      // R11 startup ones and garbage after done
      send_bits(32'h00FF_0F0F, 32);
      chk(done && err_n && !frame_valid, "R11 ignored after done", {done, err_n, frame_valid}, 3'b110);
      pulse_reprog();
      chk(err_n && !done && !length_valid, "R13 reprog from done", {err_n, done, length_valid}, 3'b100);
    end

    // R2 zero before eight ones is noise; R12 bit_en low ignored
    send_bits(7'b1111111, 7);
    send_bit(1'b0);
    chk(err_n, "R2 early zero no error", err_n, 1);
    send_bits(4'hF, 4);
    send_bits(4'b0010, 4);
    chk(err_n && !length_valid, "R2 short run not accepted", {err_n, length_valid}, 2'b10);
    pulse_reprog();

    // R3 preamble mismatch
    send_bits(8'hFF, 8);
    send_bits(4'b0011, 4);
    chk(!err_n, "R3 preamble", err_n, 0);
    pulse_reprog();
    chk(err_n, "R13 reprog from error", err_n, 1);

    // R5 fill mismatch
    send_bits(8'hFF, 8);
    send_bits(4'b0010, 4);
    send_bits(24'h123456, 24);
    send_bits(4'b1101, 4);
    chk(!err_n, "R5 fill", err_n, 0);
    pulse_reprog();

    // R6 start bit mismatch, with R12 idle toggles first
    send_header(24'h1, 8);
    repeat (6) begin
      @(negedge clk);
      bit_in = ~bit_in;
    end
    chk(err_n && !frame_valid, "R12 bit_en low ignored", err_n, 1);
    send_frame(8'h11, 4'b0110);
    chk(frame_valid && frame_data == 8'h11 && frame_idx == 0, "R12 stream intact", frame_data, 8'h11);
    send_bit(1'b1);
    chk(!err_n, "R6 start bit", err_n, 0);
    // R10 input ignored in error
    send_frame(8'h22, 4'b0110);
    chk(!err_n && !frame_valid, "R10 locked", {err_n, frame_valid}, 2'b00);
    send_bits(8'b01111111, 8);
    chk(!err_n && !done, "R10 no done", {err_n, done}, 2'b00);
    pulse_reprog();

    // R8 trailer mismatch
    send_header(24'h2, 9);
    send_frame(8'h33, 4'b0111);
    chk(!err_n && !frame_valid, "R8 trailer", {err_n, frame_valid}, 2'b00);
    pulse_reprog();

    // R9 postamble mismatch
    send_header(24'h3, 8);
    for (int f = 0; f < FC; f++) send_frame(8'(f), 4'b0110);
    send_bits(8'b01111110, 8);
    chk(!err_n && !done, "R9 bad postamble", {err_n, done}, 2'b00);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule